// File: doc/BRIEF.md
# Interrupt-Level Trap CSR Sequencer

This block keeps the machine-mode and supervisor-mode trap state of a core whose interrupt controller works with numeric interrupt levels. When the core takes a trap, the block stacks the interrupt enable of the target mode and records the mode the trap came from. It also records the trapped PC, the cause and the interrupt level that was active before the trap. When the core executes a machine or supervisor return, the block unwinds that state. This restores the enable, the privilege mode and the interrupt level, and it supplies the return PC.

The core drives one-cycle strobes: a trap strobe with its target mode, its PC, an interrupt flag, a cause code and, for interrupts, the new level; or a return strobe with the mode that returns. Privilege arbitration, pending and priority logic, vectoring and debug mode stay outside. The block assumes that the core issues only returns that are legal in the current mode. A combinational read port shows the packed state words.

Top module: `trap_csr_seq`

## Requirements
- R1: After synchronous active-low reset the mode is machine (code 2'b11). All enable and previous-enable bits are 0, both previous-privilege fields are user (mpp 2'b00, spp 0), and all levels, previous levels, PCs and causes are 0.
- R2: On trap entry into mode x, xPIE takes the value xIE had before the trap and xIE becomes 0. The other mode's enable bits are unchanged.
- R3: On trap entry, xPP takes the mode the trap came from (mode codes U=2'b00, S=2'b01, M=2'b11; spp is 1 for S and 0 for U), and the current mode becomes x.
- R4: On trap entry, xepc takes trap_pc_i. ret_pc_o shows mepc when ret_m_i is 1 and sepc when it is 0.
- R5: On trap entry, the cause of mode x stores the interrupt flag (1 for an interrupt, 0 for an exception) and the cause code.
- R6: On trap entry, for exceptions and interrupts alike, xpil takes the level of the interrupted context. For a machine trap from S this is the supervisor level; for any other machine trap it is the machine level; for a supervisor trap it is the supervisor level. An interrupt then sets the target mode's level to trap_lvl_i. An exception leaves both levels unchanged.
- R7: On xRET, xIE takes xPIE, xPIE becomes 1, the mode becomes xPP and xPP becomes user.
- R8: An MRET whose mpp is S writes mpil into the supervisor level and leaves the machine level unchanged. Any other MRET writes mpil into the machine level. An SRET writes spil into the supervisor level.
- R9: When trap and return strobes arrive in the same cycle, only the trap is performed.
- R10: A trap that requests supervisor mode while the current mode is machine is taken into machine mode.
- R11: csr_rdata_o decodes csr_addr_i as follows:
  - Address 0, status: bit0 sie, bit1 mie, bit2 spie, bit3 mpie, bit4 spp, bits6:5 mpp.
  - Address 1: mepc.
  - Address 2, mcause: bit31 interrupt flag, bits23:16 mpil, bits11:0 code.
  - Address 3, levels: bits15:8 machine level, bits7:0 supervisor level.
  - Address 4: sepc.
  - Address 5: scause, in the mcause layout.
  - Addresses 6 and 7: read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_i | input | 1 | Trap taken this cycle |
| trap_to_m_i | input | 1 | Trap target: 1 machine, 0 supervisor |
| trap_pc_i | input | XLEN | PC of the interrupted or faulting instruction |
| trap_irq_i | input | 1 | 1 for interrupt, 0 for exception |
| trap_code_i | input | CODE_W | Interrupt ID or exception code |
| trap_lvl_i | input | LVL_W | Level of the interrupt being taken |
| ret_i | input | 1 | Return executed this cycle |
| ret_m_i | input | 1 | Return mode: 1 MRET, 0 SRET; also selects ret_pc_o |
| csr_addr_i | input | 3 | Read port address |
| priv_o | output | 2 | Current mode |
| mie_o | output | 1 | Machine interrupt enable |
| sie_o | output | 1 | Supervisor interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| spie_o | output | 1 | Supervisor previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| spp_o | output | 1 | Supervisor previous privilege |
| mil_o | output | LVL_W | Current machine interrupt level |
| sil_o | output | LVL_W | Current supervisor interrupt level |
| mpil_o | output | LVL_W | Machine previous level |
| spil_o | output | LVL_W | Supervisor previous level |
| ret_pc_o | output | XLEN | Return PC |
| csr_rdata_o | output | XLEN | Read port data |

## Verification
The block has no write port, so set enables, non-zero levels and a machine return into supervisor mode can be reached only through chains of traps and returns. The stimulus therefore issues back-to-back returns to turn enable bits on. It then takes a supervisor interrupt at one level and a machine interrupt from supervisor mode at another level. After that an MRET restores the supervisor level while the machine level must stay put. Same-cycle trap and return strobes, and supervisor requests made while in machine mode, are applied inside that chain.

// File: rtl/trap_csr_pkg.sv
// Shared types and read-port layout for the trap CSR sequencer.
// Assumes a two-bit privilege encoding with user, supervisor and machine only.
package trap_csr_pkg;
    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    localparam int CSR_AW = 3;
    localparam logic [CSR_AW-1:0] CSR_STATUS = 3'd0;
    localparam logic [CSR_AW-1:0] CSR_MEPC   = 3'd1;
    localparam logic [CSR_AW-1:0] CSR_MCAUSE = 3'd2;
    localparam logic [CSR_AW-1:0] CSR_LEVELS = 3'd3;
    localparam logic [CSR_AW-1:0] CSR_SEPC   = 3'd4;
    localparam logic [CSR_AW-1:0] CSR_SCAUSE = 3'd5;

    localparam int CAUSE_PIL_LSB = 16;
endpackage

// File: rtl/trap_csr_mbank.sv
// Machine-mode trap state: enable stack, previous privilege, epc, cause and
// the machine interrupt level. Assumes trap_en_i and ret_en_i are exclusive.
// An MRET that returns to supervisor mode hands the saved level to the
// supervisor bank through sil_wr_o / sil_wr_val_o.
module trap_csr_mbank
    import trap_csr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LVL_W  = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_en_i,
    input  logic              ret_en_i,
    input  priv_e             from_priv_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              irq_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [LVL_W-1:0]  sil_i,
    output logic              ie_o,
    output logic              pie_o,
    output priv_e             pp_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              cause_irq_o,
    output logic [CODE_W-1:0] cause_code_o,
    output logic [LVL_W-1:0]  pil_o,
    output logic [LVL_W-1:0]  il_o,
    output logic              sil_wr_o,
    output logic [LVL_W-1:0]  sil_wr_val_o
);
    logic              ie_q, pie_q;
    priv_e             pp_q;
    logic [XLEN-1:0]   epc_q;
    logic              irq_q;
    logic [CODE_W-1:0] code_q;
    logic [LVL_W-1:0]  pil_q, il_q;
    logic [LVL_W-1:0]  save_lvl;

    // Level of the interrupted context: supervisor level when coming from S.
    always_comb begin
        save_lvl = (from_priv_i == PRIV_S) ? sil_i : il_q;
    end

    // Trap entry stacks state; MRET unwinds it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            pie_q  <= 1'b0;
            pp_q   <= PRIV_U;
            epc_q  <= '0;
            irq_q  <= 1'b0;
            code_q <= '0;
            pil_q  <= '0;
            il_q   <= '0;
        end else if (trap_en_i) begin
            pie_q  <= ie_q;
            ie_q   <= 1'b0;
            pp_q   <= from_priv_i;
            epc_q  <= pc_i;
            irq_q  <= irq_i;
            code_q <= code_i;
            pil_q  <= save_lvl;
            if (irq_i) begin
                il_q <= lvl_i;
            end
        end else if (ret_en_i) begin
            ie_q  <= pie_q;
            pie_q <= 1'b1;
            pp_q  <= PRIV_U;
            if (pp_q != PRIV_S) begin
                il_q <= pil_q;
            end
        end
    end

    // Return to supervisor mode routes the saved level to the supervisor bank.
    always_comb begin
        sil_wr_o     = ret_en_i && (pp_q == PRIV_S);
        sil_wr_val_o = pil_q;
    end

    assign ie_o         = ie_q;
    assign pie_o        = pie_q;
    assign pp_o         = pp_q;
    assign epc_o        = epc_q;
    assign cause_irq_o  = irq_q;
    assign cause_code_o = code_q;
    assign pil_o        = pil_q;
    assign il_o         = il_q;

    // R2: entry stacks the enable and clears it.
    p_m_entry_stack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_en_i |=> (!ie_q && pie_q == $past(ie_q)));
    // R3: entry records the mode it came from.
    p_m_entry_pp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_en_i |=> (pp_q == $past(from_priv_i)));
    // R4: entry captures the PC.
    p_m_entry_epc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_en_i |=> (epc_q == $past(pc_i)));
    // R6: an exception leaves the machine level untouched.
    p_m_exc_keeps_lvl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_en_i && !irq_i) |=> $stable(il_q));
    // R7: return sets the previous enable and resets the previous privilege.
    p_m_ret_unstack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en_i |=> (pie_q && pp_q == PRIV_U && ie_q == $past(pie_q)));
    // R8: a return to supervisor mode keeps the machine level.
    p_m_ret_to_s_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en_i && pp_q == PRIV_S) |=> $stable(il_q));
endmodule

// File: rtl/trap_csr_sbank.sv
// Supervisor-mode trap state: enable stack, previous privilege (1 bit),
// epc, cause and the supervisor interrupt level. Assumes trap_en_i, ret_en_i
// and ext_wr_i are never asserted together; ext_wr_i carries the level
// restored by an MRET into supervisor mode.
module trap_csr_sbank
    import trap_csr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LVL_W  = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_en_i,
    input  logic              ret_en_i,
    input  priv_e             from_priv_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              irq_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic              ext_wr_i,
    input  logic [LVL_W-1:0]  ext_val_i,
    output logic              ie_o,
    output logic              pie_o,
    output logic              pp_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              cause_irq_o,
    output logic [CODE_W-1:0] cause_code_o,
    output logic [LVL_W-1:0]  pil_o,
    output logic [LVL_W-1:0]  il_o
);
    logic              ie_q, pie_q, pp_q;
    logic [XLEN-1:0]   epc_q;
    logic              irq_q;
    logic [CODE_W-1:0] code_q;
    logic [LVL_W-1:0]  pil_q, il_q;

    // Trap entry stacks state; SRET unwinds it; MRET to S loads the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            pie_q  <= 1'b0;
            pp_q   <= 1'b0;
            epc_q  <= '0;
            irq_q  <= 1'b0;
            code_q <= '0;
            pil_q  <= '0;
            il_q   <= '0;
        end else if (trap_en_i) begin
            pie_q  <= ie_q;
            ie_q   <= 1'b0;
            pp_q   <= (from_priv_i == PRIV_S);
            epc_q  <= pc_i;
            irq_q  <= irq_i;
            code_q <= code_i;
            pil_q  <= il_q;
            if (irq_i) begin
                il_q <= lvl_i;
            end
        end else if (ret_en_i) begin
            ie_q  <= pie_q;
            pie_q <= 1'b1;
            pp_q  <= 1'b0;
            il_q  <= pil_q;
        end else if (ext_wr_i) begin
            il_q <= ext_val_i;
        end
    end

    assign ie_o         = ie_q;
    assign pie_o        = pie_q;
    assign pp_o         = pp_q;
    assign epc_o        = epc_q;
    assign cause_irq_o  = irq_q;
    assign cause_code_o = code_q;
    assign pil_o        = pil_q;
    assign il_o         = il_q;

    // R2: entry stacks the enable and clears it.
    p_s_entry_stack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_en_i |=> (!ie_q && pie_q == $past(ie_q)));
    // R6: entry saves the prior supervisor level.
    p_s_entry_pil_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_en_i |=> (pil_q == $past(il_q)));
    // R8: SRET restores the saved level.
    p_s_ret_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en_i |=> (il_q == $past(pil_q) && pie_q));
endmodule

// File: rtl/trap_csr_rdmux.sv
// Combinational read port: packs the trap state into fixed word layouts.
// Assumes LVL_W fits both level fields and CODE_W + LVL_W fits below XLEN-1.
module trap_csr_rdmux
    import trap_csr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LVL_W  = 8,
    parameter int CODE_W = 12
) (
    input  logic [CSR_AW-1:0] addr_i,
    input  logic              sie_i,
    input  logic              mie_i,
    input  logic              spie_i,
    input  logic              mpie_i,
    input  logic              spp_i,
    input  logic [1:0]        mpp_i,
    input  logic [XLEN-1:0]   mepc_i,
    input  logic              mirq_i,
    input  logic [CODE_W-1:0] mcode_i,
    input  logic [LVL_W-1:0]  mpil_i,
    input  logic [LVL_W-1:0]  mil_i,
    input  logic [LVL_W-1:0]  sil_i,
    input  logic [XLEN-1:0]   sepc_i,
    input  logic              sirq_i,
    input  logic [CODE_W-1:0] scode_i,
    input  logic [LVL_W-1:0]  spil_i,
    output logic [XLEN-1:0]   data_o
);
    localparam int IRQ_BIT = XLEN - 1;

    // Select and pack the addressed word.
    always_comb begin
        data_o = '0;
        unique case (addr_i)
            CSR_STATUS: data_o[6:0] = {mpp_i, spp_i, mpie_i, spie_i, mie_i, sie_i};
            CSR_MEPC:   data_o = mepc_i;
            CSR_MCAUSE: begin
                data_o[IRQ_BIT]                     = mirq_i;
                data_o[CAUSE_PIL_LSB +: LVL_W]      = mpil_i;
                data_o[CODE_W-1:0]                  = mcode_i;
            end
            CSR_LEVELS: data_o[2*LVL_W-1:0] = {mil_i, sil_i};
            CSR_SEPC:   data_o = sepc_i;
            CSR_SCAUSE: begin
                data_o[IRQ_BIT]                     = sirq_i;
                data_o[CAUSE_PIL_LSB +: LVL_W]      = spil_i;
                data_o[CODE_W-1:0]                  = scode_i;
            end
            default:    data_o = '0;
        endcase
    end
endmodule

// File: rtl/trap_csr_seq.sv
// Top of the trap CSR sequencer. Decodes trap and return strobes, holds the
// current privilege mode and wires the two trap-state banks and the read port.
// Assumes the core issues only legal returns; a trap outranks a return.
module trap_csr_seq
    import trap_csr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LVL_W  = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_i,
    input  logic              trap_to_m_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    input  logic              trap_irq_i,
    input  logic [CODE_W-1:0] trap_code_i,
    input  logic [LVL_W-1:0]  trap_lvl_i,
    input  logic              ret_i,
    input  logic              ret_m_i,
    input  logic [2:0]        csr_addr_i,
    output logic [1:0]        priv_o,
    output logic              mie_o,
    output logic              sie_o,
    output logic              mpie_o,
    output logic              spie_o,
    output logic [1:0]        mpp_o,
    output logic              spp_o,
    output logic [LVL_W-1:0]  mil_o,
    output logic [LVL_W-1:0]  sil_o,
    output logic [LVL_W-1:0]  mpil_o,
    output logic [LVL_W-1:0]  spil_o,
    output logic [XLEN-1:0]   ret_pc_o,
    output logic [XLEN-1:0]   csr_rdata_o
);
    priv_e             priv_q, priv_d;
    priv_e             mpp;
    logic              m_trap, s_trap, m_ret, s_ret;
    logic              sil_wr;
    logic [LVL_W-1:0]  sil_wr_val;
    logic [XLEN-1:0]   mepc, sepc;
    logic              mirq, sirq;
    logic [CODE_W-1:0] mcode, scode;

    // Strobe decode: machine mode never traps down; trap outranks return.
    always_comb begin
        m_trap = trap_i && (trap_to_m_i || priv_q == PRIV_M);
        s_trap = trap_i && !m_trap;
        m_ret  = !trap_i && ret_i && ret_m_i;
        s_ret  = !trap_i && ret_i && !ret_m_i;
    end

    // Next privilege mode.
    always_comb begin
        priv_d = priv_q;
        if (m_trap) begin
            priv_d = PRIV_M;
        end else if (s_trap) begin
            priv_d = PRIV_S;
        end else if (m_ret) begin
            priv_d = mpp;
        end else if (s_ret) begin
            priv_d = spp_o ? PRIV_S : PRIV_U;
        end
    end

    // Current privilege register; reset enters machine mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= PRIV_M;
        end else begin
            priv_q <= priv_d;
        end
    end

    trap_csr_mbank #(.XLEN(XLEN), .LVL_W(LVL_W), .CODE_W(CODE_W)) u_mbank (
        .clk          (clk),
        .rst_n        (rst_n),
        .trap_en_i    (m_trap),
        .ret_en_i     (m_ret),
        .from_priv_i  (priv_q),
        .pc_i         (trap_pc_i),
        .irq_i        (trap_irq_i),
        .code_i       (trap_code_i),
        .lvl_i        (trap_lvl_i),
        .sil_i        (sil_o),
        .ie_o         (mie_o),
        .pie_o        (mpie_o),
        .pp_o         (mpp),
        .epc_o        (mepc),
        .cause_irq_o  (mirq),
        .cause_code_o (mcode),
        .pil_o        (mpil_o),
        .il_o         (mil_o),
        .sil_wr_o     (sil_wr),
        .sil_wr_val_o (sil_wr_val)
    );

    trap_csr_sbank #(.XLEN(XLEN), .LVL_W(LVL_W), .CODE_W(CODE_W)) u_sbank (
        .clk          (clk),
        .rst_n        (rst_n),
        .trap_en_i    (s_trap),
        .ret_en_i     (s_ret),
        .from_priv_i  (priv_q),
        .pc_i         (trap_pc_i),
        .irq_i        (trap_irq_i),
        .code_i       (trap_code_i),
        .lvl_i        (trap_lvl_i),
        .ext_wr_i     (sil_wr),
        .ext_val_i    (sil_wr_val),
        .ie_o         (sie_o),
        .pie_o        (spie_o),
        .pp_o         (spp_o),
        .epc_o        (sepc),
        .cause_irq_o  (sirq),
        .cause_code_o (scode),
        .pil_o        (spil_o),
        .il_o         (sil_o)
    );

    trap_csr_rdmux #(.XLEN(XLEN), .LVL_W(LVL_W), .CODE_W(CODE_W)) u_rdmux (
        .addr_i  (csr_addr_i),
        .sie_i   (sie_o),
        .mie_i   (mie_o),
        .spie_i  (spie_o),
        .mpie_i  (mpie_o),
        .spp_i   (spp_o),
        .mpp_i   (mpp),
        .mepc_i  (mepc),
        .mirq_i  (mirq),
        .mcode_i (mcode),
        .mpil_i  (mpil_o),
        .mil_i   (mil_o),
        .sil_i   (sil_o),
        .sepc_i  (sepc),
        .sirq_i  (sirq),
        .scode_i (scode),
        .spil_i  (spil_o),
        .data_o  (csr_rdata_o)
    );

    assign priv_o   = priv_q;
    assign mpp_o    = mpp;
    assign ret_pc_o = ret_m_i ? mepc : sepc;

    // R9: with both strobes, the trap lands in S or M, never in U.
    p_trap_over_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_i && ret_i) |=> (priv_q != PRIV_U));
    // R10: a trap in machine mode stays in machine mode and records the PC.
    p_m_no_downward_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_i && priv_q == PRIV_M) |=> (priv_q == PRIV_M && mepc == $past(trap_pc_i)));
    // R5: a machine trap records the interrupt flag.
    p_m_cause_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_trap |=> (mirq == $past(trap_irq_i)));
endmodule

// File: tb/trap_csr_seq_bench.sv
`timescale 1ns/1ps
module trap_csr_seq_bench;
    localparam int XLEN = 32;
    localparam int LW   = 8;
    localparam int CW   = 12;

    typedef struct packed {
        logic [1:0]      priv;
        logic            mie, sie, mpie, spie;
        logic [1:0]      mpp;
        logic            spp;
        logic [LW-1:0]   mil, sil, mpil, spil;
        logic [XLEN-1:0] ret_pc;
        logic [XLEN-1:0] rd;
    } snap_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_i = 0, trap_to_m_i = 0, trap_irq_i = 0, ret_i = 0, ret_m_i = 0;
    logic [XLEN-1:0] trap_pc_i = '0;
    logic [CW-1:0]   trap_code_i = '0;
    logic [LW-1:0]   trap_lvl_i = '0;
    logic [2:0]      csr_addr_i = '0;
    logic [1:0]      priv_o, mpp_o;
    logic            mie_o, sie_o, mpie_o, spie_o, spp_o;
    logic [LW-1:0]   mil_o, sil_o, mpil_o, spil_o;
    logic [XLEN-1:0] ret_pc_o, csr_rdata_o;

    always #10 clk = ~clk;

    trap_csr_seq u_trap_csr_seq (
        .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .trap_to_m_i(trap_to_m_i),
        .trap_pc_i(trap_pc_i), .trap_irq_i(trap_irq_i), .trap_code_i(trap_code_i),
        .trap_lvl_i(trap_lvl_i), .ret_i(ret_i), .ret_m_i(ret_m_i),
        .csr_addr_i(csr_addr_i), .priv_o(priv_o), .mie_o(mie_o), .sie_o(sie_o),
        .mpie_o(mpie_o), .spie_o(spie_o), .mpp_o(mpp_o), .spp_o(spp_o),
        .mil_o(mil_o), .sil_o(sil_o), .mpil_o(mpil_o), .spil_o(spil_o),
        .ret_pc_o(ret_pc_o), .csr_rdata_o(csr_rdata_o)
    );

    // Reference state kept by the bench from the requirements.
    logic [1:0]      b_priv = 2'b11, b_mpp = 2'b00;
    logic            b_mie = 0, b_sie = 0, b_mpie = 0, b_spie = 0, b_spp = 0;
    logic [LW-1:0]   b_mil = 0, b_sil = 0, b_mpil = 0, b_spil = 0;
    logic [XLEN-1:0] b_mepc = 0, b_sepc = 0;
    logic            b_mirq = 0, b_sirq = 0;
    logic [CW-1:0]   b_mcode = 0, b_scode = 0;

    snap_t expq[$];
    string tagq[$];
    int    vectors = 0;
    int    errors  = 0;
    bit    done    = 0;

    function automatic logic [XLEN-1:0] exp_rd(input logic [2:0] a);
        logic [XLEN-1:0] w;
        w = '0;
        case (a)
            3'd0: w[6:0] = {b_mpp, b_spp, b_mpie, b_spie, b_mie, b_sie};
            3'd1: w = b_mepc;
            3'd2: begin w[31] = b_mirq; w[23:16] = b_mpil; w[11:0] = b_mcode; end
            3'd3: w[15:0] = {b_mil, b_sil};
            3'd4: w = b_sepc;
            3'd5: begin w[31] = b_sirq; w[23:16] = b_spil; w[11:0] = b_scode; end
            default: w = '0;
        endcase
        return w;
    endfunction

    // Driver: applies one operation, updates the reference, queues the result.
    task automatic op(input string tag, input bit tr, input bit to_m,
                      input logic [XLEN-1:0] pc, input bit irq, input logic [CW-1:0] code,
                      input logic [LW-1:0] lvl, input bit rt, input bit rm,
                      input logic [2:0] addr);
        snap_t e;
        logic [1:0] old;
        @(negedge clk);
        trap_i = tr; trap_to_m_i = to_m; trap_pc_i = pc; trap_irq_i = irq;
        trap_code_i = code; trap_lvl_i = lvl; ret_i = rt; ret_m_i = rm;
        csr_addr_i = addr;
        @(posedge clk);
        old = b_priv;
        if (tr) begin
            if (to_m || old == 2'b11) begin
                b_mpie = b_mie; b_mie = 0; b_mpp = old; b_mepc = pc;
                b_mirq = irq; b_mcode = code;
                b_mpil = (old == 2'b01) ? b_sil : b_mil;
                if (irq) b_mil = lvl;
                b_priv = 2'b11;
            end else begin
                b_spie = b_sie; b_sie = 0; b_spp = (old == 2'b01); b_sepc = pc;
                b_sirq = irq; b_scode = code; b_spil = b_sil;
                if (irq) b_sil = lvl;
                b_priv = 2'b01;
            end
        end else if (rt) begin
            if (rm) begin
                b_mie = b_mpie; b_mpie = 1;
                if (b_mpp == 2'b01) b_sil = b_mpil; else b_mil = b_mpil;
                b_priv = b_mpp; b_mpp = 2'b00;
            end else begin
                b_sie = b_spie; b_spie = 1; b_sil = b_spil;
                b_priv = b_spp ? 2'b01 : 2'b00; b_spp = 0;
            end
        end
        e.priv = b_priv; e.mie = b_mie; e.sie = b_sie; e.mpie = b_mpie;
        e.spie = b_spie; e.mpp = b_mpp; e.spp = b_spp; e.mil = b_mil;
        e.sil = b_sil; e.mpil = b_mpil; e.spil = b_spil;
        e.ret_pc = rm ? b_mepc : b_sepc;
        e.rd = exp_rd(addr);
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    // Monitor: a quarter period after each edge, compare against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (expq.size() > 0) begin
                snap_t a, e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                a.priv = priv_o; a.mie = mie_o; a.sie = sie_o; a.mpie = mpie_o;
                a.spie = spie_o; a.mpp = mpp_o; a.spp = spp_o; a.mil = mil_o;
                a.sil = sil_o; a.mpil = mpil_o; a.spil = spil_o;
                a.ret_pc = ret_pc_o; a.rd = csr_rdata_o;
                vectors++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        op("R1 reset status",    0,0,32'h0,0,12'h0,8'h0, 0,1, 3'd0);
        op("R1 reset levels",    0,0,32'h0,0,12'h0,8'h0, 0,1, 3'd3);
        op("R7 mret from reset", 0,0,32'h0,0,12'h0,8'h0, 1,1, 3'd0);
        op("R7 mret sets mie",   0,0,32'h0,0,12'h0,8'h0, 1,1, 3'd0);
        op("R2 R5 R6 s irq from U", 1,0,32'h100,1,12'h009,8'h22, 0,0, 3'd5);
        op("R2 R3 R6 m exc from S", 1,1,32'h200,0,12'h002,8'h55, 0,1, 3'd2);
        op("R3 R4 m irq from M",    1,1,32'h300,1,12'h00B,8'h60, 0,1, 3'd1);
        op("R8 mret to M level",    0,0,32'h0,0,12'h0,8'h0, 1,1, 3'd3);
        op("R9 R10 trap+ret in M",  1,0,32'h340,1,12'h00C,8'h44, 1,0, 3'd2);
        op("R7 mret",               0,0,32'h0,0,12'h0,8'h0, 1,1, 3'd0);
        op("R7 mret to U",          0,0,32'h0,0,12'h0,8'h0, 1,1, 3'd0);
        op("R3 R6 s irq from U",    1,0,32'h400,1,12'h007,8'h33, 0,0, 3'd3);
        op("R6 m irq from S",       1,1,32'h500,1,12'h00D,8'h70, 0,1, 3'd2);
        op("R8 mret to S sil",      0,0,32'h0,0,12'h0,8'h0, 1,1, 3'd3);
        op("R7 R8 sret",            0,0,32'h0,0,12'h0,8'h0, 1,0, 3'd3);
        op("R7 sret sets sie",      0,0,32'h0,0,12'h0,8'h0, 1,0, 3'd0);
        op("R2 R5 s exc from U",    1,0,32'h600,0,12'h003,8'h11, 0,0, 3'd5);
        op("R4 sepc on ret pc",     0,0,32'h0,0,12'h0,8'h0, 0,0, 3'd4);
        op("R9 m trap with sret",   1,1,32'h700,0,12'h004,8'h0, 1,0, 3'd0);
        op("R11 unused addr",       0,0,32'h0,0,12'h0,8'h0, 0,1, 3'd7);
        @(negedge clk);
        trap_i = 0; ret_i = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule